// File: doc/BRIEF.md
# Crossbar-Fed Two-Stage Clock Divider Channel

This block is one output channel of a clock generator. A source crossbar selects one of up to 64 parent clocks. The chosen clock then passes through a pre-divider and a final divider, and each divider has its own gate. The block runs on a single fast system clock. Each parent clock is presented as a one-cycle tick strobe, with one tick per parent period, and the channel output is a tick strobe in the same form. Its rate is the parent rate divided by both divisors in turn.

A small register interface holds the channel's configuration:

- The 6-bit source select field and the pre-divider gate sit in one byte lane of a 32-bit select word. That word is shared with three neighbouring channels.
- A per-channel pre-divisor register holds a 10-bit divisor.
- A per-channel final register holds a 6-bit divisor, the final gate and a synchronisation-mode flag.

To disable the channel, software clears only the final gate. The channel counts as enabled exactly when that final gate bit is set.

Each divider takes up a new divisor and a new gate value only at the end of its current division period. No shortened or partial output period therefore appears when software changes the configuration.

Top module: `ck_channel`

## Requirements
- R1: The select word is at byte address 0x18 + (CH with its low two bits cleared). This channel owns the byte at bit offset 8*(CH mod 4) of that word. In that byte, bits 5:0 are the source select and bit 6 is the pre-divider gate. Writes to the other bytes of the word are ignored, and those bytes read as zero.
- R2: At address 0x58 + 4*CH, bits 9:0 hold the pre-divisor. At address 0x164 + 4*CH, bits 5:0 hold the final divisor, bit 6 holds the final gate and bit 7 holds the synchronisation-mode flag. All other bits read as zero.
- R3: A read request returns its data, with rd_valid_o high, on the clock after rd_en_i. Any address not named in R1 or R2 reads as zero.
- R4: With both gates on, the interval between output ticks is P*(p+1)*(f+1) system cycles. Here P is the selected parent tick period, p is the pre-divisor field and f is the final divisor field. A field value of zero passes ticks through.
- R5: The select value s routes parent tick input s; s = 63 is a valid choice.
- R6: With the pre-divider gate clear, no output tick appears.
- R7: With the final gate clear, no output tick appears, and en_o is low. Clearing the final gate leaves the pre-divider gate unchanged. en_o equals the final gate bit.
- R8: A divisor written in the middle of a division period does not change the length of that period. The new value governs the next period.
- R9: After reset, every register field is zero, en_o and sync_mode_o are low, and no output tick appears.
- R10: sync_mode_o follows bit 7 of the final register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Parent clock tick strobes, one per parent period |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | AW | Register byte address |
| wdata_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_data_o | output | 32 | Read data, registered |
| rd_valid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| out_tick_o | output | 1 | Divided output tick |
| en_o | output | 1 | Channel enabled (final gate bit) |
| sync_mode_o | output | 1 | Synchronisation-mode flag |

## Verification
The bench drives parents with distinct tick periods. A crossbar that indexes the wrong source therefore shows up as a wrong output interval, and so does a divider that treats a field value v as v rather than v+1. Select value 63 and the 1023 pre-divisor cover the edges of the fields.

The bench writes the shared select word with every byte lane populated. A decode that takes the wrong lane, or that keeps foreign bytes, fails on read-back.

A new divisor is written just after an output tick of a long period. A divider that loads immediately would cut that period short.

The gating tests cover both gates. A design whose disable also clears the pre-divider gate fails the read-back, and a gate that fails to suppress ticks fails the pulse count.

// File: rtl/ck_channel_pkg.sv
package ck_channel_pkg;
  localparam int SEL_BASE = 'h18;
  localparam int PRE_BASE = 'h58;
  localparam int FIN_BASE = 'h164;
  localparam int SEL_FIELD_W = 6;
  localparam int PRE_FIELD_W = 10;
  localparam int FIN_FIELD_W = 6;

  function automatic int sel_word_addr(input int ch);
    return SEL_BASE + (ch & ~3);
  endfunction

  function automatic int sel_lane_shift(input int ch);
    return (ch % 4) * 8;
  endfunction

  function automatic int pre_addr(input int ch);
    return PRE_BASE + 4 * ch;
  endfunction

  function automatic int fin_addr(input int ch);
    return FIN_BASE + 4 * ch;
  endfunction
endpackage

// File: rtl/ck_regs.sv
module ck_regs
  import ck_channel_pkg::*;
#(
  parameter int CH = 5,
  parameter int AW = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [31:0]            wdata_i,
  input  logic                   rd_en_i,
  output logic [31:0]            rd_data_o,
  output logic                   rd_valid_o,
  output logic [SEL_FIELD_W-1:0] sel_o,
  output logic                   pgate_o,
  output logic [PRE_FIELD_W-1:0] pdiv_o,
  output logic [FIN_FIELD_W-1:0] fdiv_o,
  output logic                   fgate_o,
  output logic                   sync_o
);
  localparam logic [AW-1:0] SEL_A = AW'(sel_word_addr(CH));
  localparam logic [AW-1:0] PRE_A = AW'(pre_addr(CH));
  localparam logic [AW-1:0] FIN_A = AW'(fin_addr(CH));
  localparam int LANE = sel_lane_shift(CH);

  logic [31:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (addr_i == SEL_A) begin
      rd_mux[LANE +: SEL_FIELD_W] = sel_o;
      rd_mux[LANE + SEL_FIELD_W]  = pgate_o;
    end else if (addr_i == PRE_A) begin
      rd_mux[PRE_FIELD_W-1:0] = pdiv_o;
    end else if (addr_i == FIN_A) begin
      rd_mux[FIN_FIELD_W-1:0] = fdiv_o;
      rd_mux[6] = fgate_o;
      rd_mux[7] = sync_o;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o  <= '0;
      rd_valid_o <= 1'b0;
      sel_o      <= '0;
      pgate_o    <= 1'b0;
      pdiv_o     <= '0;
      fdiv_o     <= '0;
      fgate_o    <= 1'b0;
      sync_o     <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_mux;
      if (wr_en_i) begin
        if (addr_i == SEL_A) begin
          sel_o   <= wdata_i[LANE +: SEL_FIELD_W];
          pgate_o <= wdata_i[LANE + SEL_FIELD_W];
        end else if (addr_i == PRE_A) begin
          pdiv_o <= wdata_i[PRE_FIELD_W-1:0];
        end else if (addr_i == FIN_A) begin
          fdiv_o  <= wdata_i[FIN_FIELD_W-1:0];
          fgate_o <= wdata_i[6];
          sync_o  <= wdata_i[7];
        end
      end
    end
  end
endmodule

// File: rtl/ck_xbar.sv
module ck_xbar #(
  parameter int NSRC  = 64,
  parameter int SEL_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NSRC-1:0]  src_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int NPAD = 1 << SEL_W;
  logic [NPAD-1:0] padded;

  generate
    if (NSRC == NPAD) begin : g_full
      assign padded = src_i;
    end else begin : g_pad
      assign padded = {{(NPAD-NSRC){1'b0}}, src_i};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) tick_o <= 1'b0;
    else     tick_o <= padded[sel_i];
  end
endmodule

// File: rtl/ck_div.sv
module ck_div #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  input  logic         gate_i,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt;
  logic [W-1:0] cur_div;
  logic         gate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      cur_div <= '0;
      gate_q  <= 1'b0;
      tick_o  <= 1'b0;
    end else begin
      tick_o <= 1'b0;
      if (tick_i) begin
        if (cnt == cur_div) begin
          cnt     <= '0;
          tick_o  <= gate_q;
          cur_div <= div_i;
          gate_q  <= gate_i;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ck_channel.sv
module ck_channel
  import ck_channel_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int CH   = 5,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  input  logic            rd_en_i,
  output logic [31:0]     rd_data_o,
  output logic            rd_valid_o,
  output logic            out_tick_o,
  output logic            en_o,
  output logic            sync_mode_o
);
  logic [SEL_FIELD_W-1:0] sel;
  logic                   pgate;
  logic [PRE_FIELD_W-1:0] pdiv;
  logic [FIN_FIELD_W-1:0] fdiv;
  logic                   fgate;
  logic                   sel_tick;
  logic                   pre_tick;

  ck_regs #(.CH(CH), .AW(AW)) regs_i (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rd_en_i(rd_en_i), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .sel_o(sel), .pgate_o(pgate),
    .pdiv_o(pdiv), .fdiv_o(fdiv), .fgate_o(fgate), .sync_o(sync_mode_o)
  );

  ck_xbar #(.NSRC(NSRC), .SEL_W(SEL_FIELD_W)) xbar_i (
    .clk(clk), .rst(rst), .src_i(src_i), .sel_i(sel), .tick_o(sel_tick)
  );

  ck_div #(.W(PRE_FIELD_W)) pre_i (
    .clk(clk), .rst(rst), .tick_i(sel_tick), .gate_i(pgate),
    .div_i(pdiv), .tick_o(pre_tick)
  );

  ck_div #(.W(FIN_FIELD_W)) fin_i (
    .clk(clk), .rst(rst), .tick_i(pre_tick), .gate_i(fgate),
    .div_i(fdiv), .tick_o(out_tick_o)
  );

  assign en_o = fgate;
endmodule

// File: rtl/ck_channel_chk.sv
module ck_channel_chk (
  input logic clk,
  input logic rst,
  input logic sel_tick,
  input logic pre_tick,
  input logic out_tick_o,
  input logic rd_en_i,
  input logic rd_valid_o
);
  a_r4_out_follows_pre: assert property (@(posedge clk) disable iff (rst)
    out_tick_o |-> $past(pre_tick));

  a_r5_pre_follows_sel: assert property (@(posedge clk) disable iff (rst)
    pre_tick |-> $past(sel_tick));

  a_r3_read_latency: assert property (@(posedge clk) disable iff (rst)
    rd_en_i |=> rd_valid_o);

  a_r3_no_stray_valid: assert property (@(posedge clk) disable iff (rst)
    rd_valid_o |-> $past(rd_en_i));

  a_r9_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_tick_o);
endmodule

bind ck_channel ck_channel_chk chk_i (
  .clk(clk), .rst(rst), .sel_tick(sel_tick), .pre_tick(pre_tick),
  .out_tick_o(out_tick_o), .rd_en_i(rd_en_i), .rd_valid_o(rd_valid_o)
);

// File: tb/ck_channel_tb_top.sv
module ck_channel_tb_top;
  localparam int PERIOD = 10;
  localparam int NSRC = 64;
  localparam int CH = 5;
  localparam int AW = 12;
  localparam logic [AW-1:0] SEL_A = 12'h01C;
  localparam logic [AW-1:0] PRE_A = 12'h06C;
  localparam logic [AW-1:0] FIN_A = 12'h178;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NSRC-1:0] src = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic rd_valid, out_tick, en, sync_mode;
  int cyc = 0;
  int checks = 0, errors = 0;

  ck_channel #(.NSRC(NSRC), .CH(CH), .AW(AW)) dut_i (
    .clk(clk), .rst(rst), .src_i(src), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rd_en_i(rd_en), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .out_tick_o(out_tick), .en_o(en),
    .sync_mode_o(sync_mode)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic int per(input int k);
    return 2 + (k % 5);
  endfunction

  always @(negedge clk) begin
    cyc++;
    for (int k = 0; k < NSRC; k++) src[k] <= ((cyc % per(k)) == 0);
  end

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d, output logic v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rd_data; v = rd_valid;
  endtask

  task automatic cfg(input int s, input int p, input int f, input bit pg, input bit fg);
    wr(SEL_A, 32'(((pg ? 64 : 0) + s) << 8));
    wr(PRE_A, 32'(p));
    wr(FIN_A, 32'((fg ? 64 : 0) + f));
  endtask

  task automatic wait_pulse(output int t);
    t = -1;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (out_tick) begin t = cyc; break; end
    end
  endtask

  task automatic count_pulses(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (out_tick) c++;
    end
  endtask

  typedef struct packed { logic [7:0] s; logic [15:0] p; logic [7:0] f; } vec_t;
  localparam vec_t VECS [8] = '{
    '{8'd0, 16'd0, 8'd0}, '{8'd1, 16'd0, 8'd0}, '{8'd7, 16'd2, 8'd0},
    '{8'd13, 16'd1, 8'd3}, '{8'd63, 16'd0, 8'd5}, '{8'd20, 16'd3, 8'd2},
    '{8'd4, 16'd9, 8'd1}, '{8'd0, 16'd1023, 8'd0}
  };

  initial begin
    #(PERIOD * 190000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d; logic v; int t0, t1, t2, c;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    chk("R9 en_o", en, 0);
    chk("R9 sync_mode_o", sync_mode, 0);
    count_pulses(100, c); chk("R9 no ticks", c, 0);
    rd(SEL_A, d, v); chk("R9 select word", d, 0);
    chk("R3 valid", v, 1);
    rd(FIN_A, d, v); chk("R9 final reg", d, 0);

    // R1: shared select word lanes
    wr(SEL_A, 32'hA5C5_7FAA);
    rd(SEL_A, d, v); chk("R1 lane decode", d, 32'h0000_7F00);
    wr(12'h018, 32'hFFFF_FFFF);
    rd(SEL_A, d, v); chk("R1 other word ignored", d, 32'h0000_7F00);
    // R2: field masks
    wr(PRE_A, 32'hFFFF_FFFF);
    rd(PRE_A, d, v); chk("R2 pre mask", d, 32'h3FF);
    wr(FIN_A, 32'hFFFF_FFFF);
    rd(FIN_A, d, v); chk("R2 final mask", d, 32'hFF);
    chk("R10 sync on", sync_mode, 1);
    chk("R7 en_o on", en, 1);
    wr(FIN_A, 32'h0000_0040);
    chk("R10 sync off", sync_mode, 0);
    // R3: unmapped
    rd(12'h100, d, v); chk("R3 unmapped", d, 0);

    // R4 R5: vector table
    foreach (VECS[i]) begin
      cfg(VECS[i].s, VECS[i].p, VECS[i].f, 1'b1, 1'b1);
      repeat (3) wait_pulse(t0);
      wait_pulse(t0); wait_pulse(t1);
      chk("R4 R5 interval", t1 - t0,
          per(VECS[i].s) * (VECS[i].p + 1) * (VECS[i].f + 1));
    end

    // R8: mid-period divisor change
    cfg(0, 0, 20, 1'b1, 1'b1);
    repeat (3) wait_pulse(t0);
    wait_pulse(t0);
    wr(FIN_A, 32'h40);
    wait_pulse(t1); wait_pulse(t2);
    chk("R8 old period kept", t1 - t0, 42);
    chk("R8 new period next", t2 - t1, 2);

    // R6: pre gate off
    cfg(0, 0, 0, 1'b0, 1'b1);
    repeat (50) @(negedge clk);
    count_pulses(300, c); chk("R6 pre gate off", c, 0);

    // R7: disable clears only final gate
    cfg(0, 0, 0, 1'b1, 1'b1);
    wr(FIN_A, 32'h0);
    chk("R7 en_o off", en, 0);
    repeat (50) @(negedge clk);
    count_pulses(300, c); chk("R7 final gate off", c, 0);
    rd(SEL_A, d, v); chk("R7 pre gate kept", d, 32'h0000_4000);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule